// File: doc/BRIEF.md
# MDIO Management Master

This block is the serial management master for a set of Ethernet PHYs. A host writes a small bank of registers through a plain write strobe and reads them back through a combinational read port. Selected register writes launch a management frame on the MDC/MDIO pair. The frame can use either the short frame format with 5-bit register numbers or the extended format with 16-bit register addresses. The host polls a busy flag in the configuration register to learn when a frame has finished.

Clause 22 frames carry the PHY address and a 5-bit register number. In Clause 45 mode, a register address is first sent in an address frame, and a write or read frame follows. On a read, the master releases MDIO from the turnaround onward and shifts in the PHY's reply. If no device pulls the second turnaround bit low, the read is flagged as failed and the data register returns all ones.

The MDC rate comes from a programmable divider. A divider of zero keeps the bus silent. A configuration bit selects which MDC edge launches new MDIO bits, and the opposite edge samples incoming bits.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads zero (configuration at address 0, control at 1, address at 2, data at 3), MDC is low and MDIO is not driven.
- R2: With the extended-format bit (configuration bit 1) clear, writing the data register launches a 64-bit frame, sent MSB first: 32 ones, start 01, opcode 01, the 5-bit PHY address (control bits 4:0), the 5-bit register number (control bits 9:5), turnaround 10, then data bits 15:0.
- R3: With configuration bit 1 set, writing the address register launches a frame with start 00, opcode 00 and the written bits 15:0 in the data slot. With bit 1 clear, the same write launches no frame.
- R4: In extended mode, write frames use start 00 and opcode 01, and read frames use start 00 and opcode 11. The device address comes from control bits 9:5.
- R5: Writing control with bit 15 set updates the address fields and launches a read frame (short-format opcode 10). MDIO output enable is low for bits 46 to 63. The 16 bits sampled in bits 48 to 63 appear in data register bits 15:0 once busy clears.
- R6: If the second turnaround bit (bit 47) is sampled high, configuration bit 2 is set and the data register reads 0xFFFF. Launching the next read clears bit 2.
- R7: While a frame is running, each MDC half-period lasts exactly divider+1 system clocks. The divider sits in configuration bits 25:16. MDC is low when idle.
- R8: While the divider is zero, no write launches a frame. MDC stays low and busy stays clear.
- R9: When configuration bit 3 is set, MDIO changes only together with a falling MDC edge and is sampled on the rising edge. When bit 3 is clear, the edges are the other way round.
- R10: Busy (configuration bit 0) rises on the clock edge that accepts the launching write. It stays set for exactly 128×(divider+1) system clocks.
- R11: Any register write made while busy is set is discarded. It changes no register and launches no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 26 | Register write data |
| reg_rdata | output | 26 | Contents of the selected register |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value to drive on the pad |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
Every cycle, the in-line assertions check four things:
- the turnaround and data bits of a read are never driven, and write frames drive every bit;
- the bit position and MDC phase move only on divider ticks, and the tick counter never exceeds the divider;
- configuration and data stay frozen while busy;
- no frame starts with a zero divider.

Only the bench scenarios can show the remaining behaviour. These are the exact bit sequence of each frame type, the PHY reply reaching the data register, the all-ones result and error flag when no device answers, the measured half-period and busy length, and the edge on which MDIO changes for each edge setting.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, frame kinds and frame builder for the MDIO master.
// Assumes 64-bit frames with a full 32-bit preamble.
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam logic [5:0] TA_FIRST   = 6'd46;
    localparam logic [5:0] TA_SECOND  = 6'd47;
    localparam logic [5:0] DATA_FIRST = 6'd48;
    localparam logic [5:0] LAST_BIT   = 6'(FRAME_BITS - 1);

    localparam logic [1:0] RA_CFG  = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_ADDR = 2'd2;
    localparam logic [1:0] RA_DATA = 2'd3;

    localparam int CTRL_RD_BIT = 15;

    typedef enum logic [1:0] {
        K_ADDR  = 2'd0,
        K_WRITE = 2'd1,
        K_READ  = 2'd2
    } frame_kind_e;

    // Assemble the full serial word, MSB sent first.
    function automatic logic [63:0] build_frame(input logic c45, input frame_kind_e kind,
                                                input logic [4:0] port_a, input logic [4:0] dev_a,
                                                input logic [15:0] payload);
        logic [1:0] st;
        logic [1:0] op;
        logic [1:0] ta;
        logic [15:0] body;
        st = c45 ? 2'b00 : 2'b01;
        unique case (kind)
            K_ADDR:  op = 2'b00;
            K_READ:  op = c45 ? 2'b11 : 2'b10;
            default: op = 2'b01;
        endcase
        ta   = (kind == K_READ) ? 2'b11 : 2'b10;
        body = (kind == K_READ) ? 16'hFFFF : payload;
        return {32'hFFFF_FFFF, st, op, port_a, dev_a, ta, body};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
// Module: mdio_clkgen
// Emits a one-cycle tick every div+1 system clocks while run is high.
// Assumes div is held stable while run is high; div of zero yields no ticks.
module mdio_clkgen #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (div != '0) && (cnt == div);

    // Count system clocks within one MDC half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_WITHIN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cnt <= div)); // R7

endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
// Module: mdio_frame_eng
// Shifts one 64-bit management frame out on MDIO. Each bit has two MDC
// halves: in half A the bit is driven, and at the start of half B MDIO is sampled.
// Assumes launch is only asserted while idle and neg_edge is stable while busy.
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    input  logic [63:0] launch_frame,
    input  logic        launch_read,
    input  logic        tick,
    input  logic        neg_edge,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done_rd,
    output logic [15:0] rx_data,
    output logic        rx_err
);

    logic        half;
    logic [5:0]  idx;
    logic [63:0] sh;
    logic        rd;
    logic        oe;
    logic [15:0] rxs;
    logic        ta_bad;
    logic        done_q;
    logic [5:0]  idx_nxt;

    assign idx_nxt = idx + 6'd1;
    assign mdc     = busy && (half ? neg_edge : !neg_edge);
    assign mdio_o  = sh[63];
    assign mdio_oe = oe;
    assign done_rd = done_q;
    assign rx_data = rxs;
    assign rx_err  = ta_bad;

    // Frame sequencer: launch, per-half advance, sampling and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            half   <= 1'b0;
            idx    <= '0;
            sh     <= '1;
            rd     <= 1'b0;
            oe     <= 1'b0;
            rxs    <= '0;
            ta_bad <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch && !busy) begin
                busy   <= 1'b1;
                half   <= 1'b0;
                idx    <= '0;
                sh     <= launch_frame;
                rd     <= launch_read;
                oe     <= 1'b1;
                ta_bad <= 1'b0;
            end else if (busy && tick) begin
                if (!half) begin
                    half <= 1'b1;
                    if (rd && idx == TA_SECOND) begin
                        ta_bad <= mdio_i;
                    end
                    if (rd && idx >= DATA_FIRST) begin
                        rxs <= {rxs[14:0], mdio_i};
                    end
                end else if (idx == LAST_BIT) begin
                    busy   <= 1'b0;
                    half   <= 1'b0;
                    oe     <= 1'b0;
                    sh     <= '1;
                    done_q <= rd;
                end else begin
                    half <= 1'b0;
                    idx  <= idx_nxt;
                    sh   <= {sh[62:0], 1'b1};
                    oe   <= !(rd && idx_nxt >= TA_FIRST);
                end
            end
        end
    end

    AST_TA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd && idx >= TA_FIRST) |-> !mdio_oe); // R5
    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd) |-> mdio_oe); // R2
    AST_ADVANCE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> ($stable(idx) && $stable(half))); // R7
    AST_ERR_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ta_bad) |-> $past(rd)); // R6

endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
// Module: mdio_regs
// Host-visible register bank. Decodes the writes that launch frames and
// captures read results. Assumes a single write per cycle; all writes are
// dropped while the frame engine reports busy.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 10,
    localparam int REG_W = 16 + DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic             done_rd,
    input  logic [15:0]      rx_data,
    input  logic             rx_err,
    output logic             launch,
    output logic [63:0]      launch_frame,
    output logic             launch_read,
    output logic             cfg_neg,
    output logic [DIV_W-1:0] cfg_div
);

    logic             c45_q;
    logic             neg_q;
    logic             err_q;
    logic [DIV_W-1:0] div_q;
    logic [4:0]       phy_q;
    logic [4:0]       dev_q;
    logic [15:0]      addr_q;
    logic [15:0]      data_q;
    logic             accept;
    frame_kind_e      kind;
    logic [4:0]       pa;
    logic [4:0]       da;

    assign accept  = reg_wr && !busy;
    assign cfg_neg = neg_q;
    assign cfg_div = div_q;

    // Decide whether this write launches a frame, and with which fields.
    always_comb begin
        launch = 1'b0;
        kind   = K_WRITE;
        pa     = phy_q;
        da     = dev_q;
        if (accept && div_q != '0) begin
            case (reg_addr)
                RA_CTRL: begin
                    if (reg_wdata[CTRL_RD_BIT]) begin
                        launch = 1'b1;
                        kind   = K_READ;
                        pa     = reg_wdata[4:0];
                        da     = reg_wdata[9:5];
                    end
                end
                RA_ADDR: begin
                    if (c45_q) begin
                        launch = 1'b1;
                        kind   = K_ADDR;
                    end
                end
                RA_DATA: begin
                    launch = 1'b1;
                    kind   = K_WRITE;
                end
                default: ;
            endcase
        end
    end

    assign launch_frame = build_frame(c45_q, kind, pa, da, reg_wdata[15:0]);
    assign launch_read  = (kind == K_READ);

    // Register updates from host writes and from completed reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c45_q  <= 1'b0;
            neg_q  <= 1'b0;
            err_q  <= 1'b0;
            div_q  <= '0;
            phy_q  <= '0;
            dev_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                case (reg_addr)
                    RA_CFG: begin
                        c45_q <= reg_wdata[1];
                        neg_q <= reg_wdata[3];
                        div_q <= reg_wdata[16 +: DIV_W];
                    end
                    RA_CTRL: begin
                        phy_q <= reg_wdata[4:0];
                        dev_q <= reg_wdata[9:5];
                    end
                    RA_ADDR: addr_q <= reg_wdata[15:0];
                    default: data_q <= reg_wdata[15:0];
                endcase
            end
            if (launch && launch_read) begin
                err_q <= 1'b0;
            end
            if (done_rd) begin
                err_q  <= rx_err;
                data_q <= rx_err ? 16'hFFFF : rx_data;
            end
        end
    end

    // Read mux over the four registers.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CFG: begin
                reg_rdata[0]          = busy;
                reg_rdata[1]          = c45_q;
                reg_rdata[2]          = err_q;
                reg_rdata[3]          = neg_q;
                reg_rdata[16 +: DIV_W] = div_q;
            end
            RA_CTRL: reg_rdata[9:0]  = {dev_q, phy_q};
            RA_ADDR: reg_rdata[15:0] = addr_q;
            default: reg_rdata[15:0] = data_q;
        endcase
    end

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(div_q) && $stable(c45_q) && $stable(neg_q))); // R11
    AST_FIELDS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(phy_q) && $stable(dev_q) && $stable(data_q) && $stable(addr_q))); // R11

endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
// Module: mdio_master
// Top of the MDIO management master: register bank, MDC divider and frame
// engine. Assumes an external pad combines mdio_o/mdio_oe into the shared line.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 10,
    localparam int REG_W = 16 + DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    logic             busy;
    logic             tick;
    logic             launch;
    logic [63:0]      launch_frame;
    logic             launch_read;
    logic             cfg_neg;
    logic [DIV_W-1:0] cfg_div;
    logic             done_rd;
    logic [15:0]      rx_data;
    logic             rx_err;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .busy         (busy),
        .done_rd      (done_rd),
        .rx_data      (rx_data),
        .rx_err       (rx_err),
        .launch       (launch),
        .launch_frame (launch_frame),
        .launch_read  (launch_read),
        .cfg_neg      (cfg_neg),
        .cfg_div      (cfg_div)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (cfg_div),
        .tick  (tick)
    );

    mdio_frame_eng u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_frame (launch_frame),
        .launch_read  (launch_read),
        .tick         (tick),
        .neg_edge     (cfg_neg),
        .mdio_i       (mdio_i),
        .busy         (busy),
        .mdc          (mdc),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe),
        .done_rd      (done_rd),
        .rx_data      (rx_data),
        .rx_err       (rx_err)
    );

    AST_START_NEEDS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cfg_div != '0)); // R8
    AST_MDC_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> $stable(mdc)); // R7

endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
// Bench for mdio_master: a PHY model on the line side, directed corner cases
// and seeded random frames, checked against bench-computed expected values.
module tb_mdio_master;

    localparam int DIV_W = 10;
    localparam int REG_W = 16 + DIV_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             mdc;
    logic             mdio_o;
    logic             mdio_oe;
    logic             mdio_i = 1'b1;

    int nchk = 0;
    int nfail = 0;

    // line monitor state
    logic        neg_b = 1'b0;
    logic        present_b = 1'b1;
    logic [15:0] resp_b = '0;
    int          exp_half = 1;
    logic [63:0] cap_o, cap_oe;
    int          ncap, nedges, busy_cnt, halfper_bad, edge_bad;
    int          cyc = 0, last_edge = 0;
    logic        prev_mdc = 1'b0, prev_o = 1'b1, prev_bsy = 1'b0;

    mdio_master #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2 clk = ~clk;

    // PHY model and line monitor, sampled on the falling system clock.
    always @(negedge clk) begin
        logic bsy;
        bsy = (reg_addr == 2'd0) ? reg_rdata[0] : prev_bsy;
        if (bsy) busy_cnt++;
        if (mdc !== prev_mdc) begin
            nedges++;
            if (nedges > 1 && (cyc - last_edge) != exp_half) halfper_bad++;
            last_edge = cyc;
            if (mdc == neg_b) begin
                if (ncap < 64) begin
                    cap_o[63-ncap]  = mdio_o;
                    cap_oe[63-ncap] = mdio_oe;
                end
                ncap++;
                if (ncap == 47) mdio_i <= present_b ? 1'b0 : 1'b1;
                else if (ncap >= 48 && ncap <= 63) mdio_i <= present_b ? resp_b[63-ncap] : 1'b1;
                else mdio_i <= 1'b1;
            end
        end
        if (bsy && prev_bsy && (mdio_o !== prev_o) && !((mdc !== prev_mdc) && (mdc == !neg_b)))
            edge_bad++;
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_bsy = bsy;
        cyc++;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [REG_W-1:0] v);
        @(posedge clk); #1;
        reg_addr = a; #0.5;
        v = reg_rdata;
        reg_addr = 2'd0;
    endtask

    task automatic arm();
        ncap = 0; cap_o = '0; cap_oe = '0; nedges = 0; busy_cnt = 0;
        halfper_bad = 0; edge_bad = 0; mdio_i = 1'b1;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (reg_rdata[0] === 1'b1);
    endtask

    function automatic logic [REG_W-1:0] cfgw(input int div, input logic neg, input logic c45);
        logic [REG_W-1:0] w;
        w = '0;
        w[16 +: DIV_W] = DIV_W'(div);
        w[3] = neg;
        w[1] = c45;
        return w;
    endfunction

    // Expected serial word per the frame-format requirements (kind 0 addr, 1 write, 2 read).
    function automatic logic [63:0] exp_frame(input logic c45, input int kind,
                                              input logic [4:0] pa, input logic [4:0] da,
                                              input logic [15:0] d);
        logic [1:0] st, op;
        st = c45 ? 2'b00 : 2'b01;
        if (kind == 0) op = 2'b00;
        else if (kind == 1) op = 2'b01;
        else op = c45 ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, st, op, pa, da, (kind == 2) ? 2'b11 : 2'b10,
                (kind == 2) ? 16'hFFFF : d};
    endfunction

    task automatic run_frame(input string tag, input logic c45, input int kind,
                             input logic [4:0] pa, input logic [4:0] da, input logic [15:0] d,
                             input int div, input logic neg, input logic present,
                             input logic [15:0] resp);
        logic [63:0] mask, exp_oe;
        logic [REG_W-1:0] v;
        wr(2'd0, cfgw(div, neg, c45));
        neg_b = neg; exp_half = div + 1; present_b = present; resp_b = resp;
        if (kind != 2) wr(2'd1, REG_W'({da, pa}));
        arm();
        if (kind == 0) wr(2'd2, REG_W'(d));
        else if (kind == 1) wr(2'd3, REG_W'(d));
        else wr(2'd1, REG_W'((1 << 15) | ({da, pa})));
        wait_idle();
        mask   = (kind == 2) ? {{46{1'b1}}, 18'b0} : '1;
        exp_oe = (kind == 2) ? {{46{1'b1}}, 18'b0} : '1;
        check({tag, " sample count"}, 64'(ncap), 64'd64);
        check({tag, " frame bits"}, cap_o & mask, exp_frame(c45, kind, pa, da, d) & mask);
        check("R5 output enable pattern", cap_oe, exp_oe);
        check("R10 busy length", 64'(busy_cnt), 64'(128 * (div + 1)));
        check("R7 MDC half period", 64'(halfper_bad), 64'd0);
        check("R9 MDIO changes on drive edge", 64'(edge_bad), 64'd0);
        if (kind == 2) begin
            rd(2'd3, v);
            check(present ? "R5 read data" : "R6 all ones on no reply",
                  64'(v[15:0]), present ? 64'(resp) : 64'hFFFF);
            rd(2'd0, v);
            check("R6 error flag", 64'(v[2]), present ? 64'd0 : 64'd1);
        end else if (kind == 1) begin
            rd(2'd3, v);
            check("R2 data register holds written value", 64'(v[15:0]), 64'(d));
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [REG_W-1:0] v;
        int seed;
        arm();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 register reset value", 64'(v), 64'd0);
        end
        @(negedge clk);
        check("R1 idle line", {62'd0, mdc, mdio_oe}, 64'd0);

        // R8: zero divider refuses launch
        wr(2'd1, REG_W'(10'h065));
        arm();
        wr(2'd3, REG_W'(16'h1234));
        repeat (20) @(negedge clk);
        check("R8 no MDC edge with divider zero", 64'(nedges), 64'd0);
        rd(2'd0, v);
        check("R8 busy clear with divider zero", 64'(v[0]), 64'd0);

        // R11: writes while busy are discarded
        wr(2'd0, cfgw(3, 1'b0, 1'b0));
        neg_b = 1'b0; exp_half = 4;
        wr(2'd1, REG_W'({5'd3, 5'd5}));
        arm();
        wr(2'd3, REG_W'(16'hA5C3));
        wr(2'd3, REG_W'(16'h0F0F));
        wr(2'd0, cfgw(7, 1'b1, 1'b1));
        wr(2'd1, REG_W'((1 << 15) | 10'h3FF));
        wr(2'd2, REG_W'(16'h7777));
        wait_idle();
        check("R11 single frame sent", 64'(ncap), 64'd64);
        check("R2 C22 write frame under busy test", cap_o, exp_frame(1'b0, 1, 5'd5, 5'd3, 16'hA5C3));
        rd(2'd0, v);
        check("R11 config unchanged", 64'(v), 64'(cfgw(3, 1'b0, 1'b0)));
        rd(2'd3, v);
        check("R11 data unchanged", 64'(v), 64'hA5C3);
        rd(2'd1, v);
        check("R11 control unchanged", 64'(v), 64'({5'd3, 5'd5}));
        rd(2'd2, v);
        check("R11 address unchanged", 64'(v), 64'd0);
        repeat (30) @(negedge clk);
        check("R11 no late frame", 64'(ncap), 64'd64);

        // R3: address write in short-format mode launches nothing
        wr(2'd0, cfgw(2, 1'b0, 1'b0));
        arm();
        wr(2'd2, REG_W'(16'h4321));
        repeat (30) @(negedge clk);
        check("R3 no frame in C22 mode", 64'(nedges), 64'd0);

        // Directed frames
        run_frame("R2 C22 write", 1'b0, 1, 5'd1, 5'd2, 16'hBEEF, 1, 1'b1, 1'b1, 16'h0);
        run_frame("R5 C22 read", 1'b0, 2, 5'd31, 5'd0, 16'h0, 2, 1'b0, 1'b1, 16'h8001);
        run_frame("R3 C45 address", 1'b1, 0, 5'd7, 5'd30, 16'hFFFE, 1, 1'b0, 1'b1, 16'h0);
        run_frame("R4 C45 write", 1'b1, 1, 5'd0, 5'd1, 16'h0001, 3, 1'b1, 1'b1, 16'h0);
        run_frame("R4 C45 read", 1'b1, 2, 5'd12, 5'd9, 16'h0, 1, 1'b1, 1'b1, 16'h5AA5);
        run_frame("R6 read no reply", 1'b0, 2, 5'd4, 5'd4, 16'h0, 1, 1'b0, 1'b0, 16'h1234);
        run_frame("R6 next read clears flag", 1'b1, 2, 5'd4, 5'd4, 16'h0, 1, 1'b1, 1'b1, 16'h00FF);
        run_frame("R7 slow divider write", 1'b0, 1, 5'd9, 5'd17, 16'h6B2D, 258, 1'b1, 1'b1, 16'h0);

        // Seeded random frames
        seed = $urandom(32'd20240611);
        for (int n = 0; n < 20; n++) begin
            int kind;
            logic c45;
            kind = int'($urandom % 3);
            c45  = 1'($urandom % 2);
            if (!c45 && kind == 0) kind = 1;
            run_frame(c45 ? "R4 random C45" : "R2 random C22", c45, kind,
                      5'($urandom), 5'($urandom), 16'($urandom),
                      1 + int'($urandom % 3), 1'($urandom % 2),
                      ($urandom % 4) != 0, 16'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule